// File: doc/BRIEF.md
# Power-Fail Write-Protect Sequencer

This block supervises a battery-backed static memory. Two supply comparators report, without any timing relationship to the clock, whether the main supply has dropped under the power-fail level and whether it has dropped further, under the battery switchover level. Each flag is brought into the clock domain by a two-flop synchroniser and then passed through a glitch filter. A state machine uses the filtered flags to decide when the memory is locked and when its supply is taken from the battery. When the memory is locked, it is deselected, its data outputs float and host inputs are ignored.

When power fails while the memory interface reports an access in flight, that access may finish inside a bounded grace window. If it has not finished when the window closes, the lock is applied anyway. The battery is switched in only after the lock is in place, and it is released before the lock is lifted. After power returns, the lock is held for a long recovery interval so the host can settle. If power fails again during that interval, the interval starts over. The battery can never be selected until the main supply has been seen good once after reset.

All durations are clock counts derived from parameters. The grace window is `CLK_MHZ*GRACE_US` cycles, and the recovery interval is `CLK_MHZ*RECOV_MS*1000` cycles. A state output exposes the sequencer position for test.

Top module: `pfs_top`

## Requirements
- R1: After reset the state output reads LOCK (3'd2), `mem_lock` is 1 and `bat_sel` is 0. The state codes are RUN=0, GRACE=1, LOCK=2, BATT=3 and RECOV=4, and no other code appears.
- R2: A comparator flag change is acted on only after the synchronised level has been stable for `FILT_LEN` consecutive cycles, so the state responds `FILT_LEN+3` cycles after the change. A pulse shorter than `FILT_LEN` cycles has no effect.
- R3: In RUN, a power-fail indication with `access_busy` low moves the sequencer to LOCK, and `mem_lock` becomes 1.
- R4: In RUN, a power-fail indication with `access_busy` high moves the sequencer to GRACE with `mem_lock` still 0. It goes to LOCK on the cycle after `access_busy` is seen low, or after `GRACE_CYC` cycles in GRACE, whichever comes first.
- R5: In LOCK, once both flags are clear the sequencer enters RECOV with `mem_lock` held at 1. It stays there exactly `RECOV_CYC` cycles and then enters RUN with `mem_lock` at 0.
- R6: A power-fail indication during RECOV returns the sequencer to LOCK, and the next recovery interval runs its full `RECOV_CYC` cycles.
- R7: In LOCK, a switchover indication moves the sequencer to BATT with `bat_sel` at 1 and `mem_lock` at 1. When the switchover flag clears, it goes back to LOCK with `bat_sel` at 0. BATT is entered only from LOCK.
- R8: `bat_sel` stays 0, even with the switchover flag set, until the power-fail flag has cleared at least once since reset.
- R9: While the sequencer is in LOCK, activity on `access_busy` has no effect on the state or the outputs.
- R10: A switchover indication in RUN without a power-fail indication is treated as a power failure. The sequencer goes to LOCK, then to BATT on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_low_async | input | 1 | Comparator flag: supply below the power-fail level (asynchronous) |
| bat_low_async | input | 1 | Comparator flag: supply below the battery switchover level (asynchronous) |
| access_busy | input | 1 | Memory interface reports an access in flight |
| mem_lock | output | 1 | Write-protect and deselect: outputs float, host inputs ignored |
| bat_sel | output | 1 | 1 selects the battery as memory supply, 0 the external supply |
| seq_state | output | 3 | Current sequencer state code for test |

## Verification
A flag driven on a falling clock edge reaches the state output after exactly `FILT_LEN+3` rising edges: two for the synchroniser, `FILT_LEN` for the filter and one for the state register. The bench reads the old state one cycle before that edge and the new state on the falling edge just after it. The state reacts to `access_busy` one edge after it changes. GRACE and RECOV last exactly `GRACE_CYC` and `RECOV_CYC` cycles. The bench confirms each timer boundary by sampling the last cycle inside the state and the first cycle after it. Pulse widths and grace release points are swept over their whole range, with every timing computed from these latencies alone.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_GRACE = 3'd1,
    ST_LOCK  = 3'd2,
    ST_BATT  = 3'd3,
    ST_RECOV = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_deglitch.sv
// Two-flop synchroniser followed by a stability filter: the output takes
// the synchronised level only after it has differed for FILT_LEN edges.
module pfs_deglitch #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    meta_q;
  logic          flt_q, flt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) meta_q <= {2{RST_VAL}};
    else        meta_q <= {meta_q[0], raw_i};
  end

  always_comb begin
    flt_d = flt_q;
    cnt_d = '0;
    if (meta_q[1] != flt_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        flt_d = meta_q[1];
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= RST_VAL;
      cnt_q <= '0;
    end else begin
      flt_q <= flt_d;
      cnt_q <= cnt_d;
    end
  end

  assign flt_o = flt_q;
endmodule

// File: rtl/pfs_timer.sv
// Loadable down-counter; done while the count rests at zero.
module pfs_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;
  logic          dec_en;

  assign dec_en = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_en) cnt_q <= cnt_q - TW'(1);
  end

  assign done_o = ~dec_en;
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
#(
  parameter int TW        = 8,
  parameter int GRACE_CYC = 4,
  parameter int RECOV_CYC = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_low_i,
  input  logic          bat_low_i,
  input  logic          busy_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          lock_o,
  output logic          bat_sel_o,
  output logic [2:0]    state_o
);
  pfs_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       fail;

  assign fail = pwr_low_i | bat_low_i;

  always_comb begin
    state_d    = state_q;
    armed_d    = armed_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    case (state_q)
      ST_RUN: begin
        if (fail) begin
          if (busy_i) begin
            state_d    = ST_GRACE;
            tmr_load_o = 1'b1;
            tmr_val_o  = TW'(GRACE_CYC - 1);
          end else begin
            state_d = ST_LOCK;
          end
        end
      end
      ST_GRACE: begin
        if (!busy_i || tmr_done_i) state_d = ST_LOCK;
      end
      ST_LOCK: begin
        if (bat_low_i && armed_q) begin
          state_d = ST_BATT;
        end else if (!fail) begin
          state_d    = ST_RECOV;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(RECOV_CYC - 1);
          armed_d    = 1'b1;
        end
      end
      ST_BATT: begin
        if (!bat_low_i) state_d = ST_LOCK;
      end
      ST_RECOV: begin
        if (fail)            state_d = ST_LOCK;
        else if (tmr_done_i) state_d = ST_RUN;
      end
      default: state_d = ST_LOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LOCK;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign lock_o    = (state_q == ST_LOCK) || (state_q == ST_BATT) || (state_q == ST_RECOV);
  assign bat_sel_o = (state_q == ST_BATT);
  assign state_o   = state_q;
endmodule

// File: rtl/pfs_top.sv
module pfs_top #(
  parameter int CLK_MHZ  = 100,
  parameter int GRACE_US = 40,
  parameter int RECOV_MS = 50,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_low_async,
  input  logic       bat_low_async,
  input  logic       access_busy,
  output logic       mem_lock,
  output logic       bat_sel,
  output logic [2:0] seq_state
);
  localparam int GRACE_CYC = CLK_MHZ * GRACE_US;
  localparam int RECOV_CYC = CLK_MHZ * RECOV_MS * 1000;
  localparam int MAX_CYC   = (GRACE_CYC > RECOV_CYC) ? GRACE_CYC : RECOV_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam int NFLAG     = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync;
  logic [NFLAG-1:0] flag_raw, flag_flt;
  logic             tmr_load, tmr_done;
  logic [TW-1:0]    tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  // bit 0: power-fail level, bit 1: switchover level
  assign flag_raw = {bat_low_async, pwr_low_async};

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    pfs_deglitch #(
      .FILT_LEN(FILT_LEN),
      .RST_VAL (1'b1)
    ) u_dg (
      .clk  (clk),
      .rst_n(rst_sync),
      .raw_i(flag_raw[gi]),
      .flt_o(flag_flt[gi])
    );
  end

  pfs_timer #(.TW(TW)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_sync),
    .load_i    (tmr_load),
    .load_val_i(tmr_val),
    .done_o    (tmr_done)
  );

  pfs_fsm #(
    .TW       (TW),
    .GRACE_CYC(GRACE_CYC),
    .RECOV_CYC(RECOV_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync),
    .pwr_low_i (flag_flt[0]),
    .bat_low_i (flag_flt[1]),
    .busy_i    (access_busy),
    .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load),
    .tmr_val_o (tmr_val),
    .lock_o    (mem_lock),
    .bat_sel_o (bat_sel),
    .state_o   (seq_state)
  );
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk
  import pfs_pkg::*;
#(
  parameter int GRACE_CYC = 4,
  parameter int RECOV_CYC = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_lock,
  input logic       bat_sel,
  input logic [2:0] seq_state
);
  int unsigned gcnt_q, rcnt_q;
  logic        seen_recov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q       <= 0;
      rcnt_q       <= 0;
      seen_recov_q <= 1'b0;
    end else begin
      gcnt_q <= (seq_state == ST_GRACE) ? gcnt_q + 1 : 0;
      rcnt_q <= (seq_state == ST_RECOV) ? rcnt_q + 1 : 0;
      if (seq_state == ST_RECOV) seen_recov_q <= 1'b1;
    end
  end

  a_r1_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd4);

  a_r4_grace_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_GRACE) |-> (gcnt_q < GRACE_CYC));

  a_r4_grace_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_GRACE && $past(seq_state) != ST_GRACE) |-> ($past(seq_state) == ST_RUN));

  a_r5_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RUN && $past(seq_state) == ST_RECOV) |-> (rcnt_q == RECOV_CYC));

  a_r5_run_after_recov: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_RUN && $past(seq_state) != ST_RUN) |-> ($past(seq_state) == ST_RECOV));

  a_r7_batt_locked: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> mem_lock);

  a_r7_batt_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_sel) |-> ($past(seq_state) == ST_LOCK));

  a_r8_batt_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> seen_recov_q);
endmodule

bind pfs_top pfs_chk #(
  .GRACE_CYC(GRACE_CYC),
  .RECOV_CYC(RECOV_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_lock (mem_lock),
  .bat_sel  (bat_sel),
  .seq_state(seq_state)
);

// File: tb/tb_pfs_top.sv
`timescale 1ns/1ps
module tb_pfs_top;
  localparam int CLK_MHZ  = 1;
  localparam int GRACE_US = 6;
  localparam int RECOV_MS = 1;
  localparam int FILT_LEN = 3;
  localparam int G   = CLK_MHZ * GRACE_US;
  localparam int R   = CLK_MHZ * RECOV_MS * 1000;
  localparam int LAT = FILT_LEN + 3;

  localparam logic [2:0] S_RUN = 3'd0, S_GRACE = 3'd1, S_LOCK = 3'd2,
                         S_BATT = 3'd3, S_RECOV = 3'd4;

  logic clk = 1'b0;
  logic rst_n, pwr_low, bat_low, busy;
  logic mem_lock, bat_sel;
  logic [2:0] seq_state;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pfs_top #(.CLK_MHZ(CLK_MHZ), .GRACE_US(GRACE_US), .RECOV_MS(RECOV_MS),
            .FILT_LEN(FILT_LEN)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_low_async(pwr_low), .bat_low_async(bat_low),
    .access_busy(busy), .mem_lock(mem_lock), .bat_sel(bat_sel), .seq_state(seq_state));

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] st, input logic lk, input logic bs);
    nchk++;
    if (seq_state !== st || mem_lock !== lk || bat_sel !== bs) begin
      nfail++;
      $display("FAIL %s: state=%0d lock=%0b bat=%0b, expected state=%0d lock=%0b bat=%0b",
               req, seq_state, mem_lock, bat_sel, st, lk, bs);
    end
  endtask

  task automatic full_recovery(input string req);
    cyc(R - 1); chk(req, S_RECOV, 1, 0);
    cyc(1);     chk(req, S_RUN, 0, 0);
  endtask

  task automatic power_up(input string req);
    pwr_low = 0;
    cyc(LAT - 1); chk(req, S_LOCK, 1, 0);
    cyc(1);       chk(req, S_RECOV, 1, 0);
    full_recovery(req);
  endtask

  task automatic power_down(input string req);
    pwr_low = 1;
    cyc(LAT - 1); chk(req, S_RUN, 0, 0);
    cyc(1);       chk(req, S_LOCK, 1, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rst_n = 0; pwr_low = 1; bat_low = 1; busy = 0;
    cyc(3);
    chk("R1 in reset", S_LOCK, 1, 0);
    rst_n = 1;
    cyc(4);
    chk("R1 after reset", S_LOCK, 1, 0);

    // R8: switchover flag set since reset, supply never good yet
    cyc(50);
    chk("R8 battery isolated", S_LOCK, 1, 0);
    bat_low = 0;
    cyc(10);
    chk("R8 still locked", S_LOCK, 1, 0);

    power_up("R5 first power-up");
    power_down("R3 fail no access");

    // R9: busy activity while locked
    for (int i = 0; i < 20; i++) begin
      busy = ~busy;
      cyc(1);
      chk("R9 busy ignored in lock", S_LOCK, 1, 0);
    end
    busy = 0;

    // R7: battery in and out
    bat_low = 1;
    cyc(LAT - 1); chk("R7 before switch", S_LOCK, 1, 0);
    cyc(1);       chk("R7 battery on", S_BATT, 1, 1);
    cyc(20);      chk("R7 battery held", S_BATT, 1, 1);
    bat_low = 0;
    cyc(LAT - 1); chk("R7 before release", S_BATT, 1, 1);
    cyc(1);       chk("R7 battery off", S_LOCK, 1, 0);

    // R6: fail during recovery restarts it
    pwr_low = 0;
    cyc(LAT);     chk("R6 recovering", S_RECOV, 1, 0);
    cyc(100);     chk("R6 mid recovery", S_RECOV, 1, 0);
    pwr_low = 1;
    cyc(LAT);     chk("R6 back to lock", S_LOCK, 1, 0);
    power_up("R6 full restart");

    // R2: pulse width sweep on the power-fail flag
    for (int w = 1; w <= FILT_LEN + 1; w++) begin
      pwr_low = 1;
      cyc(w);
      pwr_low = 0;
      if (w < FILT_LEN) begin
        for (int k = 0; k < 2 * FILT_LEN + 6; k++) begin
          cyc(1);
          chk("R2 short pulse ignored", S_RUN, 0, 0);
        end
      end else begin
        cyc(FILT_LEN + 3 - w); chk("R2 pulse accepted", S_LOCK, 1, 0);
        cyc(w);                chk("R2 pulse end", S_RECOV, 1, 0);
        full_recovery("R2 recover");
      end
    end

    // R4: grace release sweep, d == G is the timeout case
    for (int d = 0; d <= G; d++) begin
      busy = 1;
      pwr_low = 1;
      cyc(LAT); chk("R4 grace entry", S_GRACE, 0, 0);
      if (d < G) begin
        cyc(d); chk("R4 grace held", S_GRACE, 0, 0);
        busy = 0;
        cyc(1); chk("R4 access done", S_LOCK, 1, 0);
      end else begin
        cyc(G - 1); chk("R4 grace last cycle", S_GRACE, 0, 0);
        cyc(1);     chk("R4 grace timeout", S_LOCK, 1, 0);
        busy = 0;
      end
      power_up("R4 recover");
    end

    // R10: switchover flag alone in RUN
    bat_low = 1;
    cyc(LAT - 1); chk("R10 before", S_RUN, 0, 0);
    cyc(1);       chk("R10 lock", S_LOCK, 1, 0);
    cyc(1);       chk("R10 battery", S_BATT, 1, 1);
    bat_low = 0;
    cyc(LAT - 1); chk("R10 battery held", S_BATT, 1, 1);
    cyc(1);       chk("R10 released", S_LOCK, 1, 0);
    cyc(1);       chk("R10 recovery", S_RECOV, 1, 0);
    full_recovery("R10 recover");

    summary();
  end
endmodule